// File: doc/BRIEF.md
# Paged Flash Window Streaming Reader

This block sits between a host and a large flash device that is seen through a 16 KB window. An 8-bit page register chooses which window is visible. The six page bits are split around two write-enable control bits, which keep their value whenever the page changes. The host can set the page directly and can switch the programming-voltage controls on or off.

The main function is a streaming reader for a compressed image stored across many pages. The host loads a header length and a byte count. After that, every "next byte" request either fetches one byte or reports end-of-stream. To fetch a byte, the block loads the stream's page into the page register for one cycle and reads the flash through a synchronous port with one cycle of latency. It then puts the host's page back and moves the cursor forward, crossing page boundaries on its own. An optional flash size bounds every access. A size of zero means detection mode, in which no bound applies.

Top module: `flash_page_streamer`

## Requirements
- R1: Page register layout: page bits 3:0 sit in register bits 3:0 and page bits 5:4 sit in register bits 7:6. A host page write replaces only those six bits and leaves register bits 5:4 unchanged. The flash address is the decoded page followed by the low 14 in-window offset bits.
- R2: A voltage-on command writes 01 into register bits 5:4 and a voltage-off command writes 10. Neither changes the page bits. If both arrive in the same cycle, voltage-off wins.
- R3: A stream load sets the stream page to 1, the in-page offset to the header length and the remaining count to the given length.
- R4: A byte request with a non-zero count starts a fetch cycle in which `fl_rd` is high and `fl_addr` equals {stream page, offset}. In the cycle after that, `nb_valid` is high for one cycle and `nb_data` carries the flash byte.
- R5: During the fetch cycle the page register holds the stream page, with bits 5:4 kept. In the following cycle it is back to the value it had before the request.
- R6: Each streamed byte adds one to the offset. After offset 16383 the offset wraps to 0 and the stream page goes up by one.
- R7: Each streamed byte lowers the remaining count by one. A request with a count of zero gets `nb_valid` and `nb_end` one cycle later, with `nb_data` equal to 0 and no flash read.
- R8: If `flash_size` is non-zero and the stream's absolute address is at or beyond it, the fetch does no flash read and responds with `nb_err` high and `nb_data` 0. The byte still counts as consumed. A size of zero disables this check.
- R9: Requests and loads are ignored during a fetch cycle. Page and voltage commands are ignored in a cycle where a fetch is running or is being started. A load takes precedence over a request in the same cycle, and that request is dropped.
- R10: After reset the page register is 0x00, the remaining count is 0, and `nb_valid` and `fl_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_pg_wr | input | 1 | Host page write strobe |
| host_pg | input | 6 | Page number for host write |
| wen_on | input | 1 | Programming voltage on command |
| wen_off | input | 1 | Programming voltage off command |
| pg_reg | output | 8 | Current page register value |
| str_load | input | 1 | Load stream cursor |
| str_hdr | input | WIN_BITS | Starting in-page offset (header length) |
| str_len | input | CNT_W | Number of bytes in stream |
| flash_size | input | PAGE_W+WIN_BITS+1 | Flash size in bytes, 0 = detection mode |
| nb_req | input | 1 | Next byte request |
| nb_valid | output | 1 | Response valid, one cycle |
| nb_data | output | 8 | Response byte |
| nb_end | output | 1 | End-of-stream indication |
| nb_err | output | 1 | Out-of-range indication |
| fl_rd | output | 1 | Flash read strobe |
| fl_addr | output | PAGE_W+WIN_BITS | Flash byte address |
| fl_rdata | input | 8 | Flash read data, one cycle after fl_rd |

## Verification
The bench starts a stream two bytes before the end of page 1 and checks that page 2 begins at offset 0. A cursor that failed to wrap, or that changed the page at the wrong offset, would fetch from the wrong address. It places the flash size bound in the middle of a stream and expects the bytes beyond it to come back as zero with the error flag set and no flash read. A design using the wrong comparison would either let one byte too many through or flag the last valid byte. It issues page and voltage commands during a fetch cycle, and issues a load together with a request. A design that took those commands would leave a corrupted page register after the restore, and one that took the request would return a response nobody asked for. Reads after the count reaches zero must give the end indication one cycle later, and the bench checks that no stray flash read occurs.

// File: rtl/fps_pkg.sv
// Shared constants, types and page-register helpers for the paged flash
// window streaming reader. Assumes an 8-bit page register with six page bits.
package fps_pkg;
    localparam int PAGE_W = 6;
    localparam int REG_W  = 8;
    localparam logic [1:0] WEN_ON  = 2'b01;
    localparam logic [1:0] WEN_OFF = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RESP  = 2'd2
    } fps_state_e;

    // Place a page number into the register while keeping bits 5:4.
    function automatic logic [REG_W-1:0] page_merge(input logic [REG_W-1:0] cur,
                                                    input logic [PAGE_W-1:0] pg);
        return {pg[5:4], cur[5:4], pg[3:0]};
    endfunction

    // Pull the page number out of the split register layout.
    function automatic logic [PAGE_W-1:0] page_of(input logic [REG_W-1:0] r);
        return {r[7:6], r[3:0]};
    endfunction
endpackage

// File: rtl/fps_pagereg.sv
// Page register with write-enable bits kept across page changes. During a
// stream fetch it holds the stream page and saves the prior value, which it
// puts back on the next cycle. Host commands apply only when cmd_ok is high.
module fps_pagereg
    import fps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_ok,
    input  logic              host_pg_wr,
    input  logic [PAGE_W-1:0] host_pg,
    input  logic              wen_on,
    input  logic              wen_off,
    input  logic              swap_in,
    input  logic [PAGE_W-1:0] stream_pg,
    input  logic              restore,
    output logic [REG_W-1:0]  reg_q
);
    logic [REG_W-1:0] saved_q;
    logic [REG_W-1:0] cmd_val;

    // Apply the host page write, then the voltage commands (off wins).
    always_comb begin
        cmd_val = reg_q;
        if (host_pg_wr) cmd_val = page_merge(cmd_val, host_pg);
        if (wen_off)     cmd_val[5:4] = WEN_OFF;
        else if (wen_on) cmd_val[5:4] = WEN_ON;
    end

    // Register update: swap in the stream page, restore it, or take host commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q   <= '0;
            saved_q <= '0;
        end else if (swap_in) begin
            saved_q <= reg_q;
            reg_q   <= page_merge(reg_q, stream_pg);
        end else if (restore) begin
            reg_q <= saved_q;
        end else if (cmd_ok) begin
            reg_q <= cmd_val;
        end
    end
endmodule

// File: rtl/fps_cursor.sv
// Stream cursor: page, in-page offset and remaining count. A load starts at
// page 1. Each advance moves one byte forward, carrying from the offset into
// the page, and lowers the count.
module fps_cursor
    import fps_pkg::*;
#(
    parameter int WIN_BITS = 14,
    parameter int CNT_W    = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [WIN_BITS-1:0] hdr,
    input  logic [CNT_W-1:0]    len,
    input  logic                advance,
    output logic [PAGE_W-1:0]   page_q,
    output logic [WIN_BITS-1:0] off_q,
    output logic [CNT_W-1:0]    cnt_q
);
    // Cursor state update on load or after each consumed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            page_q <= PAGE_W'(1);
            off_q  <= hdr;
            cnt_q  <= len;
        end else if (advance) begin
            {page_q, off_q} <= {page_q, off_q} + 1'b1;
            cnt_q           <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/fps_range.sv
// Range check of an absolute flash address against a configured size.
// A size of zero turns the check off (detection mode).
module fps_range #(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W:0]   size,
    output logic              oor
);
    // Flag addresses at or beyond the size when a size is given.
    always_comb oor = (size != '0) && ({1'b0, addr} >= size);
endmodule

// File: rtl/fps_seq.sv
// Request sequencer: IDLE, FETCH (one flash cycle) and RESP (one response cycle).
// A request is taken outside FETCH when no load is present. A zero count
// goes straight to RESP with the end flag set.
module fps_seq
    import fps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       load_ok,
    input  logic       cnt_zero,
    input  logic       oor,
    output fps_state_e st_q,
    output logic       start_fetch,
    output logic       end_q,
    output logic       err_q
);
    logic take;

    // Decide whether a request is accepted in this cycle.
    always_comb begin
        take        = (st_q != ST_FETCH) && req && !load_ok;
        start_fetch = take && !cnt_zero;
    end

    // State and response flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            end_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            end_q <= take && cnt_zero;
            err_q <= (st_q == ST_FETCH) && oor;
            if (take)                  st_q <= cnt_zero ? ST_RESP : ST_FETCH;
            else if (st_q == ST_FETCH) st_q <= ST_RESP;
            else                       st_q <= ST_IDLE;
        end
    end
endmodule

// File: rtl/flash_page_streamer.sv
// Top of the paged flash window streaming reader. Ties together the page
// register, stream cursor, range check and request sequencer. Assumes the
// flash returns data one cycle after a read strobe.
module flash_page_streamer
    import fps_pkg::*;
#(
    parameter int WIN_BITS = 14,
    parameter int CNT_W    = 24,
    localparam int ADDR_W  = PAGE_W + WIN_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_pg_wr,
    input  logic [PAGE_W-1:0]   host_pg,
    input  logic                wen_on,
    input  logic                wen_off,
    output logic [REG_W-1:0]    pg_reg,
    input  logic                str_load,
    input  logic [WIN_BITS-1:0] str_hdr,
    input  logic [CNT_W-1:0]    str_len,
    input  logic [ADDR_W:0]     flash_size,
    input  logic                nb_req,
    output logic                nb_valid,
    output logic [7:0]          nb_data,
    output logic                nb_end,
    output logic                nb_err,
    output logic                fl_rd,
    output logic [ADDR_W-1:0]   fl_addr,
    input  logic [7:0]          fl_rdata
);
    fps_state_e          st_q;
    logic                start_fetch, end_q, err_q, oor, load_ok, fetching;
    logic [PAGE_W-1:0]   cur_page;
    logic [WIN_BITS-1:0] cur_off;
    logic [CNT_W-1:0]    cur_cnt;
    logic [ADDR_W-1:0]   abs_addr;

    // Qualify loads and fetch state, and form the stream's absolute address.
    always_comb begin
        fetching = (st_q == ST_FETCH);
        load_ok  = str_load && !fetching;
        abs_addr = {cur_page, cur_off};
    end

    fps_pagereg u_pagereg (
        .clk(clk), .rst_n(rst_n),
        .cmd_ok(!fetching && !start_fetch),
        .host_pg_wr(host_pg_wr), .host_pg(host_pg),
        .wen_on(wen_on), .wen_off(wen_off),
        .swap_in(start_fetch), .stream_pg(cur_page),
        .restore(fetching), .reg_q(pg_reg)
    );

    fps_cursor #(.WIN_BITS(WIN_BITS), .CNT_W(CNT_W)) u_cursor (
        .clk(clk), .rst_n(rst_n), .load(load_ok), .hdr(str_hdr), .len(str_len),
        .advance(fetching), .page_q(cur_page), .off_q(cur_off), .cnt_q(cur_cnt)
    );

    fps_range #(.ADDR_W(ADDR_W)) u_range (
        .addr(abs_addr), .size(flash_size), .oor(oor)
    );

    fps_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req(nb_req), .load_ok(load_ok),
        .cnt_zero(cur_cnt == '0), .oor(oor), .st_q(st_q),
        .start_fetch(start_fetch), .end_q(end_q), .err_q(err_q)
    );

    // Flash port is addressed through the live page register; response muxing.
    always_comb begin
        fl_addr  = {page_of(pg_reg), cur_off};
        fl_rd    = fetching && !oor;
        nb_valid = (st_q == ST_RESP);
        nb_end   = nb_valid && end_q;
        nb_err   = nb_valid && err_q;
        nb_data  = (nb_valid && !end_q && !err_q) ? fl_rdata : 8'h00;
    end
endmodule

// File: rtl/fps_checker.sv
// Property checker for flash_page_streamer, bound to every instance.
// Observes ports and the cursor and sequencer state.
module fps_checker
    import fps_pkg::*;
#(
    parameter int WIN_BITS = 14,
    parameter int CNT_W    = 24
) (
    input logic                clk,
    input logic                rst_n,
    input fps_state_e          st_q,
    input logic [REG_W-1:0]    pg_reg,
    input logic                fl_rd,
    input logic                nb_valid,
    input logic                nb_end,
    input logic                nb_err,
    input logic [7:0]          nb_data,
    input logic [PAGE_W-1:0]   cur_page,
    input logic [WIN_BITS-1:0] cur_off,
    input logic [CNT_W-1:0]    cur_cnt
);
    a_r4_read_then_resp: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd |=> (nb_valid && !nb_end && !nb_err));

    a_r5_wen_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FETCH) |-> (pg_reg[5:4] == $past(pg_reg[5:4])));

    a_r5_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FETCH) |=> (pg_reg == $past(pg_reg, 2)));

    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_FETCH) && (cur_off == '1)) |=>
            ((cur_off == '0) && (cur_page == PAGE_W'($past(cur_page) + 1'b1))));

    a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FETCH) |=> (cur_cnt == CNT_W'($past(cur_cnt) - 1'b1)));

    a_r7_end_zero: assert property (@(posedge clk) disable iff (!rst_n)
        nb_end |-> (nb_valid && (nb_data == 8'h00) && !fl_rd));

    a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        nb_err |-> (nb_valid && (nb_data == 8'h00)));
endmodule

bind flash_page_streamer fps_checker #(.WIN_BITS(WIN_BITS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_q(st_q), .pg_reg(pg_reg), .fl_rd(fl_rd),
    .nb_valid(nb_valid), .nb_end(nb_end), .nb_err(nb_err), .nb_data(nb_data),
    .cur_page(cur_page), .cur_off(cur_off), .cur_cnt(cur_cnt)
);

// File: tb/flash_page_streamer_bench.sv
module flash_page_streamer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WB = 14;
    localparam int CW = 24;
    localparam int AW = 6 + WB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_pg_wr = 0, wen_on = 0, wen_off = 0, str_load = 0, nb_req = 0;
    logic [5:0]    host_pg = '0;
    logic [7:0]    pg_reg, nb_data, fl_rdata;
    logic [WB-1:0] str_hdr = '0;
    logic [CW-1:0] str_len = '0;
    logic [AW:0]   flash_size = '0;
    logic          nb_valid, nb_end, nb_err, fl_rd;
    logic [AW-1:0] fl_addr;

    int   n_checks = 0, n_fail = 0;
    bit   done = 0;
    // bench-side model of expected state
    logic [1:0]    m_wen = 2'b00;
    logic [5:0]    m_hpg = 6'd0;
    logic [5:0]    m_page = 6'd0;
    logic [WB-1:0] m_off = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_page_streamer #(.WIN_BITS(WB), .CNT_W(CW)) u_flash_page_streamer (
        .clk(clk), .rst_n(rst_n), .host_pg_wr(host_pg_wr), .host_pg(host_pg),
        .wen_on(wen_on), .wen_off(wen_off), .pg_reg(pg_reg),
        .str_load(str_load), .str_hdr(str_hdr), .str_len(str_len),
        .flash_size(flash_size), .nb_req(nb_req), .nb_valid(nb_valid),
        .nb_data(nb_data), .nb_end(nb_end), .nb_err(nb_err),
        .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_rdata(fl_rdata)
    );

    function automatic logic [7:0] fmem(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {2'b00, a[19:14]};
    endfunction

    // flash model: one cycle read latency
    always_ff @(posedge clk) if (fl_rd) fl_rdata <= fmem(fl_addr);

    function automatic logic [7:0] regval(input logic [5:0] p, input logic [1:0] w);
        return {p[5:4], w, p[3:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 page register after reset", pg_reg, 8'h00);
        check("R10 no response after reset", nb_valid, 1'b0);
        check("R10 no flash read after reset", fl_rd, 1'b0);
        nb_req = 1'b1;
        @(negedge clk);
        nb_req = 1'b0;
        check("R10 zero count gives end", nb_end, 1'b1);
        @(negedge clk);
    endtask

    task automatic t_page_cmds;
        wen_on = 1'b1; @(negedge clk); wen_on = 1'b0; m_wen = 2'b01;
        check("R2 voltage on", pg_reg, regval(m_hpg, m_wen));
        host_pg_wr = 1'b1; host_pg = 6'h2B; @(negedge clk); host_pg_wr = 1'b0; m_hpg = 6'h2B;
        check("R1 page split layout", pg_reg, 8'h9B);
        wen_off = 1'b1; @(negedge clk); wen_off = 1'b0; m_wen = 2'b10;
        check("R2 voltage off keeps page", pg_reg, 8'hAB);
        wen_on = 1'b1; wen_off = 1'b1; @(negedge clk); wen_on = 1'b0; wen_off = 1'b0;
        check("R2 off wins over on", pg_reg, 8'hAB);
    endtask

    task automatic load(input logic [WB-1:0] hdr, input int len);
        str_load = 1'b1; str_hdr = hdr; str_len = CW'(len);
        @(negedge clk);
        str_load = 1'b0;
        m_page = 6'd1; m_off = hdr;
    endtask

    // one byte request: fetch cycle at first negedge, response at second
    task automatic do_byte(input bit exp_err);
        logic [7:0]    prior = regval(m_hpg, m_wen);
        logic [AW-1:0] ea = {m_page, m_off};
        nb_req = 1'b1;
        @(negedge clk);
        nb_req = 1'b0;
        check("R8 flash read strobe", fl_rd, !exp_err);
        if (!exp_err) check("R4 flash address", fl_addr, ea);
        check("R5 stream page in register", pg_reg, regval(m_page, m_wen));
        @(negedge clk);
        check("R4 response valid", nb_valid, 1'b1);
        check("R8 error flag", nb_err, exp_err);
        check("R4 response data", nb_data, exp_err ? 8'h00 : fmem(ea));
        check("R5 register restored", pg_reg, prior);
        {m_page, m_off} = {m_page, m_off} + 1'b1;
    endtask

    task automatic do_end;
        nb_req = 1'b1;
        @(negedge clk);
        nb_req = 1'b0;
        check("R7 end indicated", {nb_valid, nb_end}, 2'b11);
        check("R7 end data zero", nb_data, 8'h00);
        check("R7 no flash read at end", fl_rd, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_stream_basic;
        flash_size = '0;
        load(WB'(16), 3);
        for (int i = 0; i < 3; i++) do_byte(1'b0);
        do_end();
    endtask

    task automatic t_wrap;
        load(WB'(16382), 4);
        for (int i = 0; i < 4; i++) do_byte(1'b0);
        check("R6 page advanced past boundary", m_page, 6'd2);
        do_end();
    endtask

    task automatic t_range;
        flash_size = (AW+1)'(16404);
        load(WB'(18), 4);
        do_byte(1'b0);
        do_byte(1'b0);
        do_byte(1'b1);
        do_byte(1'b1);
        do_end();
        flash_size = '0;
    endtask

    task automatic t_ignore;
        logic [7:0] prior = regval(m_hpg, m_wen);
        load(WB'(40), 2);
        nb_req = 1'b1;
        @(negedge clk);
        nb_req = 1'b0;
        host_pg_wr = 1'b1; host_pg = 6'h05; wen_on = 1'b1;
        @(negedge clk);
        host_pg_wr = 1'b0; wen_on = 1'b0;
        check("R9 response after busy commands", nb_valid, 1'b1);
        check("R9 commands ignored in fetch", pg_reg, prior);
        @(negedge clk);
        check("R9 register still untouched", pg_reg, prior);
        m_off = WB'(41);
        // load and request together: request dropped
        str_load = 1'b1; str_hdr = WB'(100); str_len = CW'(2); nb_req = 1'b1;
        @(negedge clk);
        str_load = 1'b0; nb_req = 1'b0; m_page = 6'd1; m_off = WB'(100);
        check("R9 request with load dropped", {fl_rd, nb_valid}, 2'b00);
        @(negedge clk);
        check("R9 no late response", nb_valid, 1'b0);
        do_byte(1'b0);
        check("R3 load sets page 1 and header", m_off, WB'(101));
        do_byte(1'b0);
        do_end();
    endtask

    initial begin
        t_reset();
        t_page_cmds();
        t_stream_basic();
        t_wrap();
        t_range();
        t_ignore();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule